// File: doc/BRIEF.md
# Asynchronous Memory Bus Front End

This block sits behind the pins of an asynchronous parallel memory bus and turns the bus activity into clean synchronous events. A sample clock that runs much faster than the bus watches the active-low chip, output and write enables and a width-select pin. From these it produces one write event per completed bus write, with the address and data that were on the pins at the right moments. It also produces the drive enables for the lower and upper data byte lanes during a read. When a lane enable is 0, that lane is high impedance.

Each enable pin passes through a two-flop synchronizer and then a pulse filter, so the filtered level changes only after the new level has held for `FILT` sample clocks. The address, data and width-select pins pass through a matching delay line. Because of this, the values captured at each enable edge are the values the pins carried at that edge, even though the filters add latency. In 8-bit mode the top data pin serves as the lowest address bit, a byte select, and the upper data lane is never driven.

Top module: `bus_frontend`

## Requirements
- R1: While reset is asserted and after it is released with the bus idle, `wr_valid`, `lo_drv`, `hi_drv`, `wr_bsel`, `wr_addr` and `wr_data` are all 0.
- R2: A write window is open while both `ce_n` and `we_n` are low. When the window closes, `wr_valid` is 1 for exactly one sample clock. It goes high on the (FILT+3)th rising sample edge after the pin edge that closed the window, counting the first edge that follows that pin edge as the 1st.
- R3: `wr_addr` holds the value of `addr_pin` at the first sample edge after the later of the two falling enable edges. It is updated together with the `wr_valid` pulse.
- R4: `wr_data` holds the value of `dq_pin` at the last sample edge before the earlier of the two rising enable edges. It is updated together with the `wr_valid` pulse.
- R5: While `ce_n` is high, no activity on `we_n` or `oe_n` produces a write pulse or any lane drive.
- R6: If the filtered `oe_n` is low at any sample clock while the write window is open, that write is discarded and no `wr_valid` pulse follows.
- R7: `lo_drv` is 1 when `ce_n` and `oe_n` are low and `we_n` is high. It rises and falls on the (FILT+3)th sample edge after the pin change.
- R8: 8-bit mode is selected by `wide_sel`=0, sampled with the address. In this mode `hi_drv` stays 0, `wr_bsel` equals `dq_pin[15]` at the address capture point, and `wr_data[15:8]` is 0.
- R9: 16-bit mode is selected by `wide_sel`=1. In this mode `hi_drv` follows `lo_drv`, `wr_bsel` is 0, and all 16 bits of `wr_data` are captured.
- R10: A low pulse on `ce_n`, `we_n` or `oe_n` that lasts fewer than FILT sample clocks has no effect. A pulse of FILT clocks or longer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide_sel | input | 1 | 1 selects 16-bit bus, 0 selects 8-bit bus |
| addr_pin | input | AW | Address pins |
| dq_pin | input | DW | Data pins as seen by the input buffers; top bit is the byte select in 8-bit mode |
| wr_valid | output | 1 | One-clock pulse per accepted write |
| wr_addr | output | AW | Captured write address |
| wr_bsel | output | 1 | Captured byte select (8-bit mode only) |
| wr_data | output | DW | Captured write data |
| lo_drv | output | 1 | Lower lane output enable (0 means high impedance) |
| hi_drv | output | 1 | Upper lane output enable (0 means high impedance) |

## Verification
Every result of this block arrives on the (FILT+3)th sample edge after the pin edge that causes it. That count is two synchronizer flops, FILT filter evaluations and one output register. The bench changes pins only at falling clock edges. It then steps through falling edges one at a time and expects a write pulse or a lane-drive change exactly at sample FILT+3, and nowhere else in the window. Address and data pins are set to their wanted values for a single sample edge only, and carry decoys before and after that edge. This way, a capture that is off by even one clock shows up as a wrong value.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
  localparam int unsigned NPINS  = 3;
  localparam int unsigned PIN_CE = 0;
  localparam int unsigned PIN_OE = 1;
  localparam int unsigned PIN_WE = 2;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_e;
endpackage

// File: rtl/bfe_deglitch.sv
module bfe_deglitch #(
  parameter int unsigned FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic sync_o,
  output logic filt_o
);
  localparam int unsigned CW = (FILT > 1) ? $clog2(FILT) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic s1_q, s2_q, filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (s2_q != filt_q) begin
      if (cnt_q == LAST) begin
        filt_d = s2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sync_o = s2_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/bfe_delay.sv
module bfe_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/bfe_write_ctrl.sv
module bfe_write_ctrl
  import bfe_pkg::*;
#(
  parameter int unsigned AW = 21,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          oe_f,
  input  logic          we_f,
  input  logic          tap_wide,
  input  logic [AW-1:0] tap_addr,
  input  logic [DW-1:0] tap_dq,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic          wr_bsel,
  output logic [DW-1:0] wr_data
);
  localparam int unsigned HALF = DW / 2;

  win_e          win_q, win_d;
  logic          bad_q, bad_d;
  logic          x8_q, x8_d;
  logic          bsel_hold_q, bsel_hold_d;
  logic [AW-1:0] addr_hold_q, addr_hold_d;
  logic [DW-1:0] late_dq_q;
  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          bsel_q, bsel_d;
  logic [DW-1:0] data_q, data_d;
  logic          active;
  logic          load_out;

  assign active = !ce_f && !we_f;

  always_comb begin
    win_d       = win_q;
    bad_d       = bad_q;
    x8_d        = x8_q;
    bsel_hold_d = bsel_hold_q;
    addr_hold_d = addr_hold_q;
    valid_d     = 1'b0;
    load_out    = 1'b0;
    case (win_q)
      WIN_IDLE: begin
        if (active) begin
          win_d       = WIN_OPEN;
          bad_d       = !oe_f;
          x8_d        = !tap_wide;
          bsel_hold_d = !tap_wide && tap_dq[DW-1];
          addr_hold_d = tap_addr;
        end
      end
      default: begin
        if (active) begin
          bad_d = bad_q || !oe_f;
        end else begin
          win_d    = WIN_IDLE;
          valid_d  = !bad_q;
          load_out = !bad_q;
        end
      end
    endcase
  end

  always_comb begin
    addr_d = addr_q;
    bsel_d = bsel_q;
    data_d = data_q;
    if (load_out) begin
      addr_d = addr_hold_q;
      bsel_d = bsel_hold_q;
      data_d = x8_q ? {{(DW-HALF){1'b0}}, late_dq_q[HALF-1:0]} : late_dq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q       <= WIN_IDLE;
      bad_q       <= 1'b0;
      x8_q        <= 1'b0;
      bsel_hold_q <= 1'b0;
      addr_hold_q <= '0;
      late_dq_q   <= '0;
      valid_q     <= 1'b0;
      addr_q      <= '0;
      bsel_q      <= 1'b0;
      data_q      <= '0;
    end else begin
      win_q       <= win_d;
      bad_q       <= bad_d;
      x8_q        <= x8_d;
      bsel_hold_q <= bsel_hold_d;
      addr_hold_q <= addr_hold_d;
      late_dq_q   <= tap_dq;
      valid_q     <= valid_d;
      addr_q      <= addr_d;
      bsel_q      <= bsel_d;
      data_q      <= data_d;
    end
  end

  assign wr_valid = valid_q;
  assign wr_addr  = addr_q;
  assign wr_bsel  = bsel_q;
  assign wr_data  = data_q;
endmodule

// File: rtl/bfe_read_ctrl.sv
module bfe_read_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_f,
  input  logic oe_f,
  input  logic we_f,
  input  logic wide,
  output logic lo_drv,
  output logic hi_drv
);
  logic lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    lo_d = !ce_f && !oe_f && we_f;
    hi_d = lo_d && wide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_drv = lo_q;
  assign hi_drv = hi_q;
endmodule

// File: rtl/bus_frontend.sv
module bus_frontend
  import bfe_pkg::*;
#(
  parameter int unsigned AW   = 21,
  parameter int unsigned DW   = 16,
  parameter int unsigned FILT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          wide_sel,
  input  logic [AW-1:0] addr_pin,
  input  logic [DW-1:0] dq_pin,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic          wr_bsel,
  output logic [DW-1:0] wr_data,
  output logic          lo_drv,
  output logic          hi_drv
);
  localparam int unsigned ADDR_TAP = FILT + 1;
  localparam int unsigned VW       = 1 + AW + DW;

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic [NPINS-1:0] pins_raw;
  logic [NPINS-1:0] pins_s;
  logic [NPINS-1:0] pins_f;
  logic [VW-1:0]    vec_in, vec_tap;
  logic             tap_wide;
  logic [AW-1:0]    tap_addr;
  logic [DW-1:0]    tap_dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign pins_raw[PIN_CE] = ce_n;
  assign pins_raw[PIN_OE] = oe_n;
  assign pins_raw[PIN_WE] = we_n;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    bfe_deglitch #(.FILT(FILT)) u_dg (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .pin    (pins_raw[p]),
      .sync_o (pins_s[p]),
      .filt_o (pins_f[p])
    );
  end

  assign vec_in = {wide_sel, addr_pin, dq_pin};

  bfe_delay #(.W(VW), .DEPTH(ADDR_TAP + 1)) u_dly (
    .clk   (clk),
    .rst_n (rst_i_n),
    .din   (vec_in),
    .dout  (vec_tap)
  );

  assign {tap_wide, tap_addr, tap_dq} = vec_tap;

  bfe_write_ctrl #(.AW(AW), .DW(DW)) u_wr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ce_f     (pins_f[PIN_CE]),
    .oe_f     (pins_f[PIN_OE]),
    .we_f     (pins_f[PIN_WE]),
    .tap_wide (tap_wide),
    .tap_addr (tap_addr),
    .tap_dq   (tap_dq),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_bsel  (wr_bsel),
    .wr_data  (wr_data)
  );

  bfe_read_ctrl u_rd (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .ce_f   (pins_f[PIN_CE]),
    .oe_f   (pins_f[PIN_OE]),
    .we_f   (pins_f[PIN_WE]),
    .wide   (tap_wide),
    .lo_drv (lo_drv),
    .hi_drv (hi_drv)
  );
endmodule

// File: rtl/bus_frontend_chk.sv
module bus_frontend_chk
  import bfe_pkg::*;
(
  input logic             clk,
  input logic             rst_i_n,
  input logic [NPINS-1:0] pins_s,
  input logic [NPINS-1:0] pins_f,
  input logic             wr_valid,
  input logic             lo_drv,
  input logic             hi_drv
);
  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_valid |=> !wr_valid); // R2

  AST_PULSE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_valid |-> ($past(pins_f[PIN_CE]) || $past(pins_f[PIN_WE]))); // R2

  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_i_n)
    hi_drv |-> lo_drv); // R9

  AST_DRIVE_FROM_ENABLES: assert property (@(posedge clk) disable iff (!rst_i_n)
    lo_drv |-> $past(!pins_f[PIN_CE] && !pins_f[PIN_OE] && pins_f[PIN_WE])); // R7

  AST_NO_DRIVE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(pins_f[PIN_CE]) |-> !lo_drv); // R5

  for (genvar p = 0; p < NPINS; p++) begin : g_flt
    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_i_n)
      (pins_f[p] != $past(pins_f[p])) |-> (pins_f[p] == $past(pins_s[p]))); // R10
  end
endmodule

bind bus_frontend bus_frontend_chk u_chk (
  .clk      (clk),
  .rst_i_n  (rst_i_n),
  .pins_s   (pins_s),
  .pins_f   (pins_f),
  .wr_valid (wr_valid),
  .lo_drv   (lo_drv),
  .hi_drv   (hi_drv)
);

// File: tb/sim_bus_frontend.sv
`timescale 1ns/1ps
module sim_bus_frontend;
  localparam int  AW   = 21;
  localparam int  DW   = 16;
  localparam int  FILT = 3;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DUE  = FILT + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wide_sel = 1'b1;
  logic [AW-1:0] addr_pin = '0;
  logic [DW-1:0] dq_pin = '0;
  logic          wr_valid, wr_bsel, lo_drv, hi_drv;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_frontend #(.AW(AW), .DW(DW), .FILT(FILT)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wide_sel(wide_sel), .addr_pin(addr_pin), .dq_pin(dq_pin),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_bsel(wr_bsel),
    .wr_data(wr_data), .lo_drv(lo_drv), .hi_drv(hi_drv)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input bit ce_fall_first, input bit ce_rise_first,
                          input bit wide, input bit bsel, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit oe_bad);
    int pulses = 0;
    bit timing_ok = 1'b1;
    logic [DW-1:0] exp_d;
    wide_sel = wide; oe_n = 1'b1; idle(8);
    addr_pin = ~a; dq_pin = 16'h5A5A;
    if (ce_fall_first) ce_n = 1'b0; else we_n = 1'b0;
    idle(3);
    if (ce_fall_first) we_n = 1'b0; else ce_n = 1'b0;
    addr_pin = a; dq_pin = {bsel, 15'h1234};
    idle(1);
    addr_pin = ~a; dq_pin = 16'h0F0F;
    idle(2);
    if (oe_bad) begin oe_n = 1'b0; idle(5); oe_n = 1'b1; end
    dq_pin = d;
    idle(3);
    if (ce_rise_first) ce_n = 1'b1; else we_n = 1'b1;
    dq_pin = ~d;
    for (int j = 1; j <= DUE + 2; j++) begin
      idle(1);
      if (wr_valid) pulses++;
      if (wr_valid != (j == DUE && !oe_bad)) timing_ok = 1'b0;
    end
    ce_n = 1'b1; we_n = 1'b1;
    if (oe_bad) begin
      check(pulses == 0, "R6", "pulse count with oe low in window", pulses, 0);
    end else begin
      check(timing_ok && pulses == 1, "R2", "pulse at due sample", pulses, 1);
      check(wr_addr == a, "R3", "captured address", wr_addr, a);
      exp_d = wide ? d : {8'h00, d[7:0]};
      check(wr_data == exp_d, wide ? "R9" : "R8", "captured data", wr_data, exp_d);
      check(wr_bsel == (wide ? 1'b0 : bsel), wide ? "R9" : "R8", "byte select",
            wr_bsel, wide ? 1'b0 : bsel);
      check(wr_data == exp_d, "R4", "data at earlier rise", wr_data, exp_d);
    end
    idle(4);
  endtask

  task automatic read_test(input bit wide);
    bit ok = 1'b1;
    wide_sel = wide; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; idle(8);
    oe_n = 1'b0;
    for (int j = 1; j <= DUE + 2; j++) begin
      idle(1);
      if (lo_drv != (j >= DUE)) ok = 1'b0;
      if (hi_drv != (wide && j >= DUE)) ok = 1'b0;
    end
    check(ok, "R7", wide ? "drive rise x16" : "drive rise x8", {lo_drv, hi_drv}, {1'b1, wide});
    check(hi_drv == wide, wide ? "R9" : "R8", "upper lane drive", hi_drv, wide);
    ok = 1'b1;
    oe_n = 1'b1;
    for (int j = 1; j <= DUE + 2; j++) begin
      idle(1);
      if (lo_drv != (j < DUE)) ok = 1'b0;
    end
    check(ok, "R7", "drive fall", lo_drv, 0);
    ce_n = 1'b1; idle(6);
  endtask

  task automatic glitch(input int pin_sel, input int n);
    int pulses = 0;
    int drives = 0;
    bit expect_hit = (n >= FILT);
    ce_n = (pin_sel == 1) ? 1'b1 : 1'b0;
    we_n = (pin_sel == 1) ? 1'b0 : 1'b1;
    oe_n = 1'b1; idle(8);
    case (pin_sel)
      0: we_n = 1'b0;
      1: ce_n = 1'b0;
      default: oe_n = 1'b0;
    endcase
    for (int j = 0; j < 2*FILT + 12; j++) begin
      if (j == n) begin we_n = (pin_sel == 1) ? 1'b0 : 1'b1; ce_n = (pin_sel == 1) ? 1'b1 : 1'b0; oe_n = 1'b1; end
      idle(1);
      if (wr_valid) pulses++;
      if (lo_drv) drives++;
    end
    if (pin_sel == 2)
      check((drives > 0) == expect_hit, "R10", "oe pulse width vs drive", drives, expect_hit);
    else
      check(pulses == (expect_hit ? 1 : 0), "R10", "enable pulse width vs write", pulses, expect_hit);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; idle(6);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    check(!wr_valid && !lo_drv && !hi_drv, "R1", "outputs in reset", {wr_valid, lo_drv, hi_drv}, 0);
    rst_n = 1'b1;
    idle(6);
    check({wr_valid, lo_drv, hi_drv, wr_bsel} == 4'b0 && wr_addr == '0 && wr_data == '0,
          "R1", "outputs after reset", {wr_valid, lo_drv, hi_drv, wr_bsel}, 0);

    for (int idx = 0; idx < 16; idx++) begin
      logic [AW-1:0] a = AW'(21'h0A5F3 * (idx + 1) + idx);
      logic [DW-1:0] d = DW'(16'h9C31 ^ (idx * 16'h1111));
      do_write(idx[0], idx[1], idx[2], idx[3], a, d, 1'b0);
    end
    do_write(1'b1, 1'b0, 1'b1, 1'b0, 21'h1ABCD, 16'hBEEF, 1'b1);
    do_write(1'b0, 1'b1, 1'b0, 1'b1, 21'h00F0F, 16'h1234, 1'b1);

    begin
      int pulses = 0;
      int drives = 0;
      ce_n = 1'b1; oe_n = 1'b0; idle(2);
      for (int j = 0; j < 30; j++) begin
        we_n = (j % 10) < 6 ? 1'b0 : 1'b1;
        idle(1);
        if (wr_valid) pulses++;
        if (lo_drv || hi_drv) drives++;
      end
      we_n = 1'b1; oe_n = 1'b1; idle(10);
      if (wr_valid) pulses++;
      check(pulses == 0, "R5", "write pulses with ce high", pulses, 0);
      check(drives == 0, "R5", "lane drives with ce high", drives, 0);
    end

    read_test(1'b1);
    read_test(1'b0);

    for (int n = 1; n <= FILT + 1; n++) begin
      glitch(0, n);
      glitch(1, n);
      glitch(2, n);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule